// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the fetch and decode logic of a small 8-bit core. It handles the start and the end of interrupt service. Four peripheral request lines enter it, each with its own pending flag and enable bit: a PWM timer, an ADC, a multi-input wakeup unit and a general timer. A fifth request comes from a software-interrupt instruction. A global enable bit, held inside the block, gates the four peripheral requests. It does not gate the software request.

When the decoder signals an instruction boundary and a request qualifies, the block starts a fixed five-cycle entry sequence. It clears the global enable and pushes the current 10-bit program counter to the stack one byte at a time. It then strobes the vector address of the winning source into the program counter. When the decoder reports a return at a boundary, the block pops the two bytes, reloads the program counter and, for the interrupt-return form only, sets the global enable again.

Pending flags are inputs only and are never modified here; clearing them is left to the service routine. The stack is a plain push/pop strobe port. It takes one byte per cycle and never stalls, so no valid/ready handshake is used: the fixed cycle count of the sequence depends on that.

Top module: `irq_sequencer`

## Requirements
- R1: Peripheral source k (pend_i/en_i bit 0 = PWM timer, 1 = ADC, 2 = wakeup, 3 = general timer) qualifies only when pend_i[k], en_i[k] and gie_o are all 1.
- R2: A software request (swi_i = 1) qualifies whatever the value of gie_o.
- R3: A sequence starts only on a clock edge where boundary_i = 1 and the block is idle; with boundary_i = 0 no request is taken.
- R4: Among qualifying requests, the software request wins, then bit 0, bit 1, bit 2 and bit 3 in that order. The vectors are 10'h3F0 (software), 10'h3F2, 10'h3F4, 10'h3F6 and 10'h3F8.
- R5: gie_o becomes 0 on the edge that starts entry. In the first entry cycle stk_push_o = 1 with stk_wdata_o = pc_i[7:0] as sampled at that edge. In the second, stk_push_o = 1 with {6'b0, pc_i[9:8]}.
- R6: busy_o is 1 for exactly five cycles of entry. pc_load_o pulses only in the fifth, with pc_addr_o equal to the winning vector.
- R7: An interrupt return (reti_i = 1 at a boundary) pops for two cycles, high byte first and then low byte. In the third cycle it pulses pc_load_o with the rebuilt address, and gie_o is 1 from the next cycle.
- R8: A plain return (ret_i = 1, reti_i = 0) has the same timing as R7 but leaves gie_o unchanged.
- R9: While idle, gie_wr_i = 1 loads gie_wd_i into gie_o on the next edge. While busy_o = 1, the write is ignored.
- R10: While busy_o = 1, boundary_i, requests and return inputs are ignored. If a return and a request arrive at the same boundary, the return runs and nothing is pushed.
- R11: After reset, gie_o = 0, busy_o = 0, and no push, pop or load strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Current instruction completes this cycle |
| pc_i | input | 10 | Return address to save on entry |
| swi_i | input | 1 | Software interrupt request |
| pend_i | input | 4 | Peripheral pending flags |
| en_i | input | 4 | Per-source enable bits |
| reti_i | input | 1 | Interrupt-return instruction at this boundary |
| ret_i | input | 1 | Plain return instruction at this boundary |
| gie_wr_i | input | 1 | Write strobe for the global enable |
| gie_wd_i | input | 1 | Value to write to the global enable |
| stk_rdata_i | input | 8 | Top-of-stack byte, valid in a pop cycle |
| busy_o | output | 1 | Entry or return sequence in progress |
| gie_o | output | 1 | Global interrupt enable |
| stk_push_o | output | 1 | Push stk_wdata_o this cycle |
| stk_pop_o | output | 1 | Pop the top byte this cycle |
| stk_wdata_o | output | 8 | Byte to push |
| pc_load_o | output | 1 | Load pc_addr_o into the program counter |
| pc_addr_o | output | 10 | Vector or restored return address |

## Verification
The embedded properties check the following on every cycle:
- the enable bit clears on the edge that starts entry and stays fixed against writes during a sequence;
- the first push carries the low byte of the sampled program counter;
- a return starts with a pop rather than a push;
- the sequencer cannot leave busy early or start without a boundary.

Priority among simultaneous sources, the mask and enable combinations, the exact vector values and the five-cycle position of the load strobe need the bench's scenarios. The same holds for the round trip of the return address through a stack model and the difference between the two return forms.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ENTRY  = 2'd1,
    PH_RETURN = 2'd2
  } seq_phase_t;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int              NUM_MSK  = 4,
  parameter int              PCW      = 10,
  parameter logic [PCW-1:0]  VEC_BASE = 10'h3F0,
  parameter int              VEC_STEP = 2
) (
  input  logic               swi_i,
  input  logic               gie_i,
  input  logic [NUM_MSK-1:0] pend_i,
  input  logic [NUM_MSK-1:0] en_i,
  output logic               req_o,
  output logic [PCW-1:0]     vec_o
);
  logic [NUM_MSK-1:0] qual;

  // each maskable source needs its flag, its enable and the global enable
  for (genvar g = 0; g < NUM_MSK; g++) begin : g_qual
    assign qual[g] = pend_i[g] & en_i[g] & gie_i;
  end

  // scan from lowest priority upward so the last hit is the winner
  always_comb begin
    req_o = swi_i | (|qual);
    vec_o = VEC_BASE;
    if (!swi_i) begin
      for (int i = NUM_MSK - 1; i >= 0; i--) begin
        if (qual[i]) vec_o = VEC_BASE + PCW'((i + 1) * VEC_STEP);
      end
    end
  end
endmodule

// File: rtl/irq_gie_reg.sv
module irq_gie_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic set_i,
  input  logic wr_i,
  input  logic wd_i,
  input  logic busy_i,
  output logic gie_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gie_o <= 1'b0;
    else if (clr_i)          gie_o <= 1'b0;
    else if (set_i)          gie_o <= 1'b1;
    else if (wr_i && !busy_i) gie_o <= wd_i;
  end

  // R5
  gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !gie_o);

  // R7
  gie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> gie_o);

  // R9
  gie_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !set_i && !clr_i) |=> (gie_o == $past(gie_o)));
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int PCW          = 10,
  parameter int SW           = 8,
  parameter int ENTRY_CYCLES = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           boundary_i,
  input  logic           req_i,
  input  logic [PCW-1:0] vec_i,
  input  logic [PCW-1:0] pc_i,
  input  logic           reti_i,
  input  logic           ret_i,
  input  logic [SW-1:0]  stk_rdata_i,
  output logic           busy_o,
  output logic           stk_push_o,
  output logic           stk_pop_o,
  output logic [SW-1:0]  stk_wdata_o,
  output logic           pc_load_o,
  output logic [PCW-1:0] pc_addr_o,
  output logic           gie_clr_o,
  output logic           gie_set_o
);
  localparam int NB = (PCW + SW - 1) / SW;
  localparam int PW = NB * SW;
  localparam int CW = $clog2(ENTRY_CYCLES + 1);

  seq_phase_t     phase_q;
  logic [CW-1:0]  cnt_q;
  logic [PW-1:0]  shf_q;
  logic [PCW-1:0] vec_q;
  logic           restore_q;

  logic ret_req, start_ret, start_ent, last_ent, last_ret, byte_slot;

  assign ret_req   = reti_i | ret_i;
  assign start_ret = (phase_q == PH_IDLE) && boundary_i && ret_req;
  assign start_ent = (phase_q == PH_IDLE) && boundary_i && !ret_req && req_i;
  assign byte_slot = cnt_q < CW'(NB);
  assign last_ent  = (phase_q == PH_ENTRY)  && (cnt_q == CW'(ENTRY_CYCLES - 1));
  assign last_ret  = (phase_q == PH_RETURN) && (cnt_q == CW'(NB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      shf_q     <= '0;
      vec_q     <= '0;
      restore_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (start_ret) begin
            phase_q   <= PH_RETURN;
            restore_q <= reti_i;
          end else if (start_ent) begin
            phase_q <= PH_ENTRY;
            shf_q   <= PW'(pc_i);
            vec_q   <= vec_i;
          end
        end
        PH_ENTRY: begin
          if (byte_slot) shf_q <= shf_q >> SW;
          if (last_ent) phase_q <= PH_IDLE;
          else          cnt_q   <= cnt_q + 1'b1;
        end
        PH_RETURN: begin
          if (byte_slot) shf_q <= (shf_q << SW) | PW'(stk_rdata_i);
          if (last_ret) phase_q <= PH_IDLE;
          else          cnt_q   <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o      = (phase_q != PH_IDLE);
  assign stk_push_o  = (phase_q == PH_ENTRY)  && byte_slot;
  assign stk_pop_o   = (phase_q == PH_RETURN) && byte_slot;
  assign stk_wdata_o = shf_q[SW-1:0];
  assign pc_load_o   = last_ent | last_ret;
  assign pc_addr_o   = last_ent ? vec_q : shf_q[PCW-1:0];
  assign gie_clr_o   = start_ent;
  assign gie_set_o   = last_ret && restore_q;

  // R5
  push_low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ent |=> (stk_push_o && (stk_wdata_o == $past(pc_i[SW-1:0]))));

  // R6
  load_ends_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |=> !busy_o);

  // R3
  no_start_without_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !boundary_i) |=> !busy_o);

  // R10
  return_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ret |=> (stk_pop_o && !stk_push_o));

  // R10
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !pc_load_o) |=> busy_o);
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int              NUM_MSK      = 4,
  parameter int              PCW          = 10,
  parameter int              SW           = 8,
  parameter int              ENTRY_CYCLES = 5,
  parameter logic [PCW-1:0]  VEC_BASE     = 10'h3F0,
  parameter int              VEC_STEP     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary_i,
  input  logic [PCW-1:0]     pc_i,
  input  logic               swi_i,
  input  logic [NUM_MSK-1:0] pend_i,
  input  logic [NUM_MSK-1:0] en_i,
  input  logic               reti_i,
  input  logic               ret_i,
  input  logic               gie_wr_i,
  input  logic               gie_wd_i,
  input  logic [SW-1:0]      stk_rdata_i,
  output logic               busy_o,
  output logic               gie_o,
  output logic               stk_push_o,
  output logic               stk_pop_o,
  output logic [SW-1:0]      stk_wdata_o,
  output logic               pc_load_o,
  output logic [PCW-1:0]     pc_addr_o
);
  logic           req;
  logic [PCW-1:0] vec;
  logic           gie_clr, gie_set;

  irq_arbiter #(
    .NUM_MSK(NUM_MSK), .PCW(PCW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_arb (
    .swi_i (swi_i),
    .gie_i (gie_o),
    .pend_i(pend_i),
    .en_i  (en_i),
    .req_o (req),
    .vec_o (vec)
  );

  irq_seq_ctrl #(
    .PCW(PCW), .SW(SW), .ENTRY_CYCLES(ENTRY_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary_i),
    .req_i      (req),
    .vec_i      (vec),
    .pc_i       (pc_i),
    .reti_i     (reti_i),
    .ret_i      (ret_i),
    .stk_rdata_i(stk_rdata_i),
    .busy_o     (busy_o),
    .stk_push_o (stk_push_o),
    .stk_pop_o  (stk_pop_o),
    .stk_wdata_o(stk_wdata_o),
    .pc_load_o  (pc_load_o),
    .pc_addr_o  (pc_addr_o),
    .gie_clr_o  (gie_clr),
    .gie_set_o  (gie_set)
  );

  irq_gie_reg u_gie (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (gie_clr),
    .set_i (gie_set),
    .wr_i  (gie_wr_i),
    .wd_i  (gie_wd_i),
    .busy_i(busy_o),
    .gie_o (gie_o)
  );
endmodule

// File: tb/irq_sequencer_tb.sv
module irq_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boundary_i = 1'b0;
  logic [9:0] pc_i = '0;
  logic       swi_i = 1'b0;
  logic [3:0] pend_i = '0;
  logic [3:0] en_i = '0;
  logic       reti_i = 1'b0;
  logic       ret_i = 1'b0;
  logic       gie_wr_i = 1'b0;
  logic       gie_wd_i = 1'b0;
  logic [7:0] stk_rdata_i;
  logic       busy_o, gie_o, stk_push_o, stk_pop_o, pc_load_o;
  logic [7:0] stk_wdata_o;
  logic [9:0] pc_addr_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .pc_i(pc_i),
    .swi_i(swi_i), .pend_i(pend_i), .en_i(en_i), .reti_i(reti_i),
    .ret_i(ret_i), .gie_wr_i(gie_wr_i), .gie_wd_i(gie_wd_i),
    .stk_rdata_i(stk_rdata_i), .busy_o(busy_o), .gie_o(gie_o),
    .stk_push_o(stk_push_o), .stk_pop_o(stk_pop_o),
    .stk_wdata_o(stk_wdata_o), .pc_load_o(pc_load_o), .pc_addr_o(pc_addr_o)
  );

  // byte stack model
  logic [7:0] smem [16];
  int sp = 0;
  always @(posedge clk) begin
    if (stk_push_o) begin smem[sp] <= stk_wdata_o; sp <= sp + 1; end
    if (stk_pop_o && sp > 0) sp <= sp - 1;
  end
  assign stk_rdata_i = (sp > 0) ? smem[sp-1] : 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_boundary();
    boundary_i = 1'b1;
    @(negedge clk);
    boundary_i = 1'b0;
  endtask

  task automatic write_gie(input bit v);
    gie_wr_i = 1'b1; gie_wd_i = v;
    @(negedge clk);
    gie_wr_i = 1'b0;
  endtask

  // called at the negedge right after the starting edge
  task automatic follow_entry(input logic [9:0] pc, input bit taken, input logic [9:0] vec);
    if (!taken) begin
      check(busy_o == 1'b0, "R1 no start", busy_o, 0);
      for (int k = 0; k < 5; k++) begin
        check(pc_load_o == 1'b0 && stk_push_o == 1'b0, "R1 no strobe", pc_load_o, 0);
        @(negedge clk);
      end
    end else begin
      check(stk_push_o && stk_wdata_o == pc[7:0], "R5 low byte", stk_wdata_o, pc[7:0]);
      check(gie_o == 1'b0, "R5 gie cleared", gie_o, 0);
      @(negedge clk);
      check(stk_push_o && stk_wdata_o == {6'b0, pc[9:8]}, "R5 high byte", stk_wdata_o, pc[9:8]);
      @(negedge clk);
      @(negedge clk);
      check(pc_load_o == 1'b0 && busy_o, "R6 no early load", pc_load_o, 0);
      @(negedge clk);
      check(pc_load_o == 1'b1, "R6 load in fifth", pc_load_o, 1);
      check(pc_addr_o == vec, "R4 vector", pc_addr_o, vec);
      @(negedge clk);
      check(busy_o == 1'b0, "R6 entry done", busy_o, 0);
    end
  endtask

  task automatic do_return(input bit full, input logic [9:0] pc, input bit exp_gie);
    reti_i = full; ret_i = !full;
    pulse_boundary();
    reti_i = 1'b0; ret_i = 1'b0;
    check(stk_pop_o && !stk_push_o, "R7 pop hi", stk_pop_o, 1);
    @(negedge clk);
    check(stk_pop_o == 1'b1, "R7 pop lo", stk_pop_o, 1);
    @(negedge clk);
    check(pc_load_o && pc_addr_o == pc, "R7 restored pc", pc_addr_o, pc);
    @(negedge clk);
    if (full) check(gie_o == exp_gie, "R7 gie after reti", gie_o, exp_gie);
    else      check(gie_o == exp_gie, "R8 gie after ret", gie_o, exp_gie);
    check(busy_o == 1'b0, "R7 return done", busy_o, 0);
  endtask

  // {pend, en, gie, swi, taken, vector}
  localparam int NV = 12;
  localparam logic [20:0] VECS [NV] = '{
    {4'b0001, 4'b0001, 1'b1, 1'b0, 1'b1, 10'h3F2},
    {4'b0001, 4'b0001, 1'b0, 1'b0, 1'b0, 10'h000},
    {4'b0001, 4'b0000, 1'b1, 1'b0, 1'b0, 10'h000},
    {4'b0000, 4'b1111, 1'b1, 1'b1, 1'b1, 10'h3F0},
    {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 10'h3F0},
    {4'b1111, 4'b1111, 1'b1, 1'b0, 1'b1, 10'h3F2},
    {4'b1110, 4'b1111, 1'b1, 1'b0, 1'b1, 10'h3F4},
    {4'b1100, 4'b1111, 1'b1, 1'b0, 1'b1, 10'h3F6},
    {4'b1000, 4'b1111, 1'b1, 1'b0, 1'b1, 10'h3F8},
    {4'b1111, 4'b1110, 1'b1, 1'b1, 1'b1, 10'h3F0},
    {4'b0110, 4'b0101, 1'b1, 1'b0, 1'b1, 10'h3F6},
    {4'b1111, 4'b0111, 1'b0, 1'b0, 1'b0, 10'h000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] pc;
    // R11 reset state
    repeat (2) @(negedge clk);
    check(!busy_o && !gie_o, "R11 reset idle", {busy_o, gie_o}, 0);
    check(!stk_push_o && !stk_pop_o && !pc_load_o, "R11 reset strobes",
          {stk_push_o, stk_pop_o, pc_load_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      write_gie(VECS[i][12]);
      check(gie_o == VECS[i][12], "R9 idle write", gie_o, VECS[i][12]);
      pend_i = VECS[i][20:17];
      en_i   = VECS[i][16:13];
      swi_i  = VECS[i][11];
      pc     = 10'h2A5 + 10'(i * 37);
      pc_i   = pc;
      pulse_boundary();
      pend_i = '0; en_i = '0; swi_i = 1'b0;
      follow_entry(pc, VECS[i][10], VECS[i][9:0]);
      if (VECS[i][10]) do_return(1'b1, pc, 1'b1);
    end

    // R3: request held without a boundary is not taken
    write_gie(1'b1);
    pend_i = 4'b0001; en_i = 4'b0001;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!busy_o && !stk_push_o, "R3 no boundary", busy_o, 0);
    end
    pend_i = '0; en_i = '0;

    // R10 and R9: inputs ignored while busy, then R8 plain return
    write_gie(1'b0);
    pc = 10'h155; pc_i = pc; swi_i = 1'b1;
    pulse_boundary();
    boundary_i = 1'b1; gie_wr_i = 1'b1; gie_wd_i = 1'b1; reti_i = 1'b1;
    check(stk_push_o && stk_wdata_o == 8'h55, "R2 swi with mask clear", stk_wdata_o, 8'h55);
    @(negedge clk);
    check(stk_push_o && stk_wdata_o == 8'h01, "R10 busy continues", stk_wdata_o, 8'h01);
    @(negedge clk);
    check(!stk_pop_o && gie_o == 1'b0, "R9 write ignored busy", gie_o, 0);
    @(negedge clk);
    boundary_i = 1'b0; gie_wr_i = 1'b0; reti_i = 1'b0; swi_i = 1'b0;
    @(negedge clk);
    check(pc_load_o && pc_addr_o == 10'h3F0, "R10 entry unaffected", pc_addr_o, 10'h3F0);
    @(negedge clk);
    check(!busy_o && gie_o == 1'b0, "R9 gie still clear", gie_o, 0);
    do_return(1'b0, pc, 1'b0);

    // R10: return and request at the same boundary
    pc = 10'h2C3; pc_i = pc; swi_i = 1'b1;
    pulse_boundary();
    swi_i = 1'b0;
    follow_entry(pc, 1'b1, 10'h3F0);
    swi_i = 1'b1; pend_i = 4'b0001; en_i = 4'b0001;
    pc_i = 10'h011;
    do_return(1'b1, pc, 1'b1);
    swi_i = 1'b0; pend_i = '0; en_i = '0;
    check(sp == 0, "R10 stack balanced", sp, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule